// File: doc/BRIEF.md
# Serial ADC Setup and Acquisition Sequencer

This block is the master end of a synchronous serial link to an external sigma-delta converter. A start pulse latches a channel number, a 12-bit filter word and a clock idle polarity. The block then sends a fixed series of eight-bit frames that program the converter's filter and mode registers. The last of these frames launches a self-calibration.

After setup the block watches an active-low data-ready line, which it passes through a synchronizer. Each time that line is active it performs a two-frame read. The first frame is a command byte that addresses the data register for reading. The second frame clocks in a 24-bit result, most significant bit first. The word is presented with a one-cycle valid pulse. After the programmed number of samples the block raises a done flag and returns to idle.

Chip select frames every transfer. The serial clock rests at its idle level whenever chip select is high. Its half period is derived from the system clock so that the link never runs faster than the slave's limit.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is high and in the cycle after it, cs_n is 1, sclk, mosi, smp_valid and done are 0.
- R2: After start, the first six frames are eight bits each, in this order: select filter-high, filter-high data, select filter-low, filter-low data, select mode, mode data. A select byte is {0, sel[2:0], rd, chan[2:0]}, with rd=0 for writes. The sel codes are 2 for filter-high, 3 for filter-low, 1 for mode and 5 for data.
- R3: The filter-high data byte is {4'b0100, filt_word[11:8]}, which sets 24-bit reads, bipolar coding and boost off. The filter-low data byte is filt_word[7:0].
- R4: The mode data byte is 8'h20. Bits 7:5 = 001 request self-calibration, gain bits 4:2 = 000 give gain 1, bit 1 = 0 turns burnout off and bit 0 = 0 turns sync off.
- R5: Bits go out on mosi MSB first. Mosi changes only while sclk is at its idle level. Mosi is stable across each edge that leaves idle. Miso is captured MSB first.
- R6: cs_n goes low for each frame and high between frames. While cs_n is high, sclk never changes.
- R7: Each sclk level lasts at least HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) system cycles, and exactly HALF during a frame.
- R8: The sclk idle level equals sclk_idle_hi as sampled at start, and it holds for the whole run.
- R9: A read begins only when the synchronized drdy_n is low. It is an eight-bit frame {0, 5, 1, chan} followed by a 24-bit frame.
- R10: After each 24-bit frame, smp_valid pulses for exactly one cycle, and smp_data holds the 24 bits received.
- R11: After NUM_SAMPLES reads, done rises together with the last smp_valid and the block idles. A start pulse during a run is ignored. A start pulse clears done.
- R12: drdy_n being active during setup causes no read before the mode data frame has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a setup and acquisition run when idle |
| chan | input | 3 | Channel number placed in every select byte |
| filt_word | input | 12 | Filter word split across the two filter frames |
| sclk_idle_hi | input | 1 | Serial clock idle level, 1 = high |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| drdy_n | input | 1 | Active-low data-ready, asynchronous |
| smp_valid | output | 1 | One-cycle pulse with a new sample |
| smp_data | output | 24 | Last received sample |
| done | output | 1 | Set when the sample count is reached |

## Verification
Two things can coincide. Data-ready can already be active at the moment the mode frame ends, and it can still be active when a sample's valid pulse fires. In both cases the wait for data-ready and the completion of a transfer happen in the same cycle. One run holds data-ready low from before start to the end, so both collisions happen on every sample. A second run holds data-ready inactive for a delay after every read. The frame log must show the six setup frames strictly first, each read command issued with data-ready low, and no frame lost or duplicated when reads follow back to back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DATA_W = 24;
  localparam int FILT_W = 12;
  localparam int NSETUP = 6;

  typedef enum logic [2:0] {SQ_IDLE, SQ_SETUP, SQ_WAIT, SQ_RDCMD, SQ_RDDATA} seq_state_t;
  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_ACT, SH_TAIL, SH_GAP} sh_state_t;

  function automatic logic [7:0] comms_byte(input logic [2:0] sel, input logic rd,
                                            input logic [2:0] ch);
    return {1'b0, sel, rd, ch};
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
  import adc_seq_pkg::*;
#(
  parameter int HALF = 34,
  parameter int MAXB = 24,
  localparam int BW = $clog2(MAXB + 1),
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            idle_hi,
  input  logic [BW-1:0]   nbits,
  input  logic [MAXB-1:0] tx,
  input  logic            miso,
  output logic            busy,
  output logic            fin,
  output logic [MAXB-1:0] rx,
  output logic            cs_n,
  output logic            sclk,
  output logic            mosi
);
  sh_state_t       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bits;
  logic [MAXB-1:0] sh;
  logic            pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SH_IDLE; cnt <= '0; bits <= '0; sh <= '0; rx <= '0;
      cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0; fin <= 1'b0; pol <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SH_IDLE: if (go) begin
          sh <= tx; bits <= nbits; pol <= idle_hi; sclk <= idle_hi;
          cs_n <= 1'b0; mosi <= tx[MAXB-1]; rx <= '0;
          cnt <= CW'(HALF - 1); st <= SH_LEAD;
        end
        SH_LEAD: if (cnt == '0) begin
          sclk <= ~pol; cnt <= CW'(HALF - 1); st <= SH_ACT;
        end else cnt <= cnt - 1'b1;
        SH_ACT: if (cnt == '0) begin
          sclk <= pol;
          rx   <= {rx[MAXB-2:0], miso};
          bits <= bits - 1'b1;
          cnt  <= CW'(HALF - 1);
          if (bits == BW'(1)) st <= SH_TAIL;
          else begin
            sh <= sh << 1; mosi <= sh[MAXB-2]; st <= SH_LEAD;
          end
        end else cnt <= cnt - 1'b1;
        SH_TAIL: if (cnt == '0) begin
          cs_n <= 1'b1; mosi <= 1'b0; cnt <= CW'(HALF - 1); st <= SH_GAP;
        end else cnt <= cnt - 1'b1;
        SH_GAP: if (cnt == '0) begin
          st <= SH_IDLE; fin <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign busy = (st != SH_IDLE);

  // Checker state: cycles the current sclk level has lasted.
  logic          sclk_d;
  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0; run_q <= CW'(HALF);
    end else begin
      sclk_d <= sclk;
      if (sclk != sclk_d)        run_q <= CW'(1);
      else if (run_q != CW'(HALF)) run_q <= run_q + 1'b1;
    end
  end

  assert_no_edge_deselected_R6: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> $stable(sclk));
  assert_half_period_min_R7: assert property (@(posedge clk) disable iff (rst)
    (sclk != sclk_d && !cs_n && $past(!cs_n)) |-> (run_q == CW'(HALF)));
  assert_mosi_moves_at_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> (sclk == pol));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int          CLK_HZ      = 200_000_000,
  parameter int          SCLK_MAX_HZ = 3_000_000,
  parameter int          NUM_SAMPLES = 1000,
  parameter logic [2:0]  SEL_MODE    = 3'd1,
  parameter logic [2:0]  SEL_FHI     = 3'd2,
  parameter logic [2:0]  SEL_FLO     = 3'd3,
  parameter logic [2:0]  SEL_DATA    = 3'd5,
  parameter logic [3:0]  FHI_FLAGS   = 4'b0100,
  parameter logic [7:0]  MODE_BYTE   = 8'h20,
  localparam int HALF  = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ),
  localparam int NBW   = $clog2(DATA_W + 1),
  localparam int SCW   = (NUM_SAMPLES < 2) ? 1 : $clog2(NUM_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        chan,
  input  logic [FILT_W-1:0] filt_word,
  input  logic              sclk_idle_hi,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              drdy_n,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              done
);
  seq_state_t        st;
  logic [2:0]        idx;
  logic              go_q;
  logic [DATA_W-1:0] tx_q;
  logic [NBW-1:0]    nb_q;
  logic [2:0]        ch_q;
  logic [FILT_W-1:0] filt_q;
  logic              pol_q;
  logic [SCW-1:0]    smp_cnt;
  logic              rdy_n_s;
  logic              sh_busy, sh_fin;
  logic [DATA_W-1:0] sh_rx;

  function automatic logic [7:0] setup_byte(input logic [2:0] i, input logic [2:0] c,
                                            input logic [FILT_W-1:0] f);
    case (i)
      3'd0:    return comms_byte(SEL_FHI, 1'b0, c);
      3'd1:    return {FHI_FLAGS, f[FILT_W-1:8]};
      3'd2:    return comms_byte(SEL_FLO, 1'b0, c);
      3'd3:    return f[7:0];
      3'd4:    return comms_byte(SEL_MODE, 1'b0, c);
      default: return MODE_BYTE;
    endcase
  endfunction

  adc_seq_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(drdy_n), .q(rdy_n_s));

  adc_seq_shifter #(.HALF(HALF), .MAXB(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .go(go_q), .idle_hi(pol_q), .nbits(nb_q), .tx(tx_q),
    .miso(miso), .busy(sh_busy), .fin(sh_fin), .rx(sh_rx),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; idx <= '0; go_q <= 1'b0; tx_q <= '0; nb_q <= '0;
      ch_q <= '0; filt_q <= '0; pol_q <= 1'b0; smp_cnt <= '0;
      smp_valid <= 1'b0; smp_data <= '0; done <= 1'b0;
    end else begin
      go_q <= 1'b0;
      smp_valid <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          ch_q <= chan; filt_q <= filt_word; pol_q <= sclk_idle_hi;
          done <= 1'b0; idx <= '0; smp_cnt <= '0;
          go_q <= 1'b1; nb_q <= NBW'(8);
          tx_q <= {setup_byte(3'd0, chan, filt_word), {(DATA_W-8){1'b0}}};
          st <= SQ_SETUP;
        end
        SQ_SETUP: if (sh_fin) begin
          if (idx == 3'(NSETUP - 1)) st <= SQ_WAIT;
          else begin
            idx  <= idx + 1'b1;
            go_q <= 1'b1;
            tx_q <= {setup_byte(3'(idx + 1'b1), ch_q, filt_q), {(DATA_W-8){1'b0}}};
          end
        end
        SQ_WAIT: if (!sh_busy && !rdy_n_s) begin
          go_q <= 1'b1; nb_q <= NBW'(8);
          tx_q <= {comms_byte(SEL_DATA, 1'b1, ch_q), {(DATA_W-8){1'b0}}};
          st <= SQ_RDCMD;
        end
        SQ_RDCMD: if (sh_fin) begin
          go_q <= 1'b1; nb_q <= NBW'(DATA_W); tx_q <= '0; st <= SQ_RDDATA;
        end
        SQ_RDDATA: if (sh_fin) begin
          smp_valid <= 1'b1;
          smp_data  <= sh_rx;
          if (smp_cnt == SCW'(NUM_SAMPLES - 1)) begin
            done <= 1'b1; st <= SQ_IDLE;
          end else begin
            smp_cnt <= smp_cnt + 1'b1; st <= SQ_WAIT;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_go_only_when_free_R6: assert property (@(posedge clk) disable iff (rst)
    go_q |-> !sh_busy);
  assert_read_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (go_q && st == SQ_RDCMD) |-> $past(!rdy_n_s));
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);
  assert_done_with_last_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> smp_valid);
  assert_no_read_in_setup_R12: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_SETUP) |-> !smp_valid);
endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  localparam int NS = 4;
  localparam int CLKF = 15_000_000;
  localparam int SMAX = 3_000_000;
  localparam int HALF_EXP = (CLKF + 2 * SMAX - 1) / (2 * SMAX);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, pol = 1'b0, miso = 1'b0, drdy_n = 1'b1;
  logic [2:0] chan = '0;
  logic [11:0] filt = '0;
  logic cs_n, sclk, mosi, smp_valid, done;
  logic [23:0] smp_data;

  adc_seq_top #(.CLK_HZ(CLKF), .SCLK_MAX_HZ(SMAX), .NUM_SAMPLES(NS)) dut (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .filt_word(filt),
    .sclk_idle_hi(pol), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .drdy_n(drdy_n), .smp_valid(smp_valid), .smp_data(smp_data), .done(done));

  int nchk = 0, nerr = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sval(input int k);
    return 24'(k * 24'h2F4D1B + 24'h80F00F);
  endfunction

  // Slave model and frame log
  logic [23:0] fr_val [64];
  int          fr_len [64];
  logic        fr_rdy [64];
  int nfr, cur_len, sidx, vidx, vcount, desel_edges, min_half, hold, rdy_delay, dcnt;
  logic [23:0] cur_val, sh_out;
  logic cur_rdy, pend_read, prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (sclk != prev_sclk) begin
      if (!cs_n && !prev_cs && hold < min_half) min_half = hold;
      hold = 1;
    end else hold++;
    if (cs_n && prev_cs && sclk != prev_sclk) desel_edges++;
    if (prev_cs && !cs_n) begin
      cur_len = 0; cur_val = '0; cur_rdy = drdy_n;
      if (pend_read) begin sh_out = sval(sidx); miso = sh_out[23]; end
    end else if (!prev_cs && !cs_n && sclk != prev_sclk) begin
      if (sclk != pol) begin cur_val = {cur_val[22:0], mosi}; cur_len++; end
      else begin sh_out = sh_out << 1; miso = sh_out[23]; end
    end else if (!prev_cs && cs_n) begin
      if (nfr < 64) begin
        fr_val[nfr] = cur_val; fr_len[nfr] = cur_len; fr_rdy[nfr] = cur_rdy;
      end
      nfr++;
      if (pend_read && cur_len == 24) begin
        pend_read = 1'b0; sidx++;
        if (rdy_delay != 0) begin drdy_n = 1'b1; dcnt = rdy_delay; end
      end else if (cur_len == 8 && cur_val[7:0] == {1'b0, 3'd5, 1'b1, chan})
        pend_read = 1'b1;
    end
    if (drdy_n && dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) drdy_n = 1'b0;
    end
    if (smp_valid) begin
      check(smp_data == sval(vidx), "R10 sample word", smp_data, sval(vidx));
      vidx++; vcount++;
    end
    prev_cs = cs_n; prev_sclk = sclk;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic run(input logic p, input logic [2:0] ch, input logic [11:0] fw,
                     input int dly, input bit mid_start);
    int guard;
    nfr = 0; sidx = 0; vidx = 0; vcount = 0; desel_edges = 0; min_half = 1000;
    pend_read = 1'b0; rdy_delay = dly; dcnt = dly;
    drdy_n = (dly == 0) ? 1'b0 : 1'b1;
    @(posedge clk); #1 pol = p; chan = ch; filt = fw; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R11 start clears done", done, 0);
    if (mid_start) begin
      repeat (300) @(posedge clk);
      #1 start = 1'b1; chan = ~ch; @(posedge clk); #1 start = 1'b0; chan = ch;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R11 done raised", done, 1);
    check(vcount == NS, "R11 sample count", vcount, NS);
    check(nfr == 6 + 2 * NS, "R11 frame count", nfr, 6 + 2 * NS);
    check(fr_val[0][7:0] == {1'b0, 3'd2, 1'b0, ch}, "R2 select filter-high", fr_val[0], {1'b0, 3'd2, 1'b0, ch});
    check(fr_val[1][7:0] == {4'b0100, fw[11:8]}, "R3 filter-high data", fr_val[1], {4'b0100, fw[11:8]});
    check(fr_val[2][7:0] == {1'b0, 3'd3, 1'b0, ch}, "R2 select filter-low", fr_val[2], {1'b0, 3'd3, 1'b0, ch});
    check(fr_val[3][7:0] == fw[7:0], "R3 filter-low data", fr_val[3], fw[7:0]);
    check(fr_val[4][7:0] == {1'b0, 3'd1, 1'b0, ch}, "R12 select mode", fr_val[4], {1'b0, 3'd1, 1'b0, ch});
    check(fr_val[5][7:0] == 8'h20, "R4 mode data", fr_val[5], 8'h20);
    for (int i = 0; i < 6; i++)
      check(fr_len[i] == 8, "R2 setup frame length", fr_len[i], 8);
    for (int k = 0; k < NS; k++) begin
      check(fr_val[6 + 2*k][7:0] == {1'b0, 3'd5, 1'b1, ch} && fr_len[6 + 2*k] == 8,
            "R9 read command", fr_val[6 + 2*k], {1'b0, 3'd5, 1'b1, ch});
      check(fr_rdy[6 + 2*k] == 1'b0, "R9 ready at read", fr_rdy[6 + 2*k], 0);
      check(fr_len[7 + 2*k] == 24, "R5 data frame length", fr_len[7 + 2*k], 24);
    end
    check(desel_edges == 0, "R6 edges while deselected", desel_edges, 0);
    check(min_half == HALF_EXP, "R7 half period", min_half, HALF_EXP);
    check(cs_n == 1'b1 && sclk == p, "R8 idle level", {cs_n, sclk}, {1'b1, p});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 link in reset", {cs_n, sclk, mosi}, 3'b100);
    check(smp_valid == 1'b0 && done == 1'b0, "R1 flags in reset", {smp_valid, done}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1 && smp_valid == 1'b0 && done == 1'b0, "R1 after reset", {cs_n, smp_valid, done}, 3'b100);
    run(1'b0, 3'd5, 12'hABC, 0, 1'b1);
    run(1'b1, 3'd2, 12'h3C5, 40, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule